// File: doc/BRIEF.md
# Overload Fault Sequencer

This block is the digital fault sequencer of a current-mode switching regulator controller. At the end of every switching cycle it receives two flags. One says that the cycle was ended by the current-limit comparator and not by the PWM comparator. The other reports over-temperature. It also receives a free-running millisecond tick. From these it drives a PWM enable and a soft-start request.

Overloaded cycles are counted up and down. A clean cycle takes one step back, so short bursts of current limiting decay away, and only a sustained net excess reaches the end-of-count. A separate span timer bounds how long an unbroken run of current-limited cycles may last in milliseconds. This covers the case where skipped pulses stretch the cycle period. Over-temperature must be seen on a run of consecutive cycles before it acts. Any trip switches the PWM off for a fixed restart interval and then re-enters soft-start. If the fault persists, the result is a slow, low-duty retry pattern.

Top module: `olp_fault_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, `pwm_en` = 1 and `ss_req` = 1: the block starts in soft-start.
- R2: A cycle report (`cyc_done` = 1) with `cyc_ilim` = 1 adds one to the overload count. The report that brings the count to `OVL_EOC` trips, and `pwm_en` reads 0 from the next clock on.
- R3: A cycle report with `cyc_ilim` = 0 takes one from the overload count, which saturates at zero. A pattern whose running net count stays below `OVL_EOC` never trips.
- R4: The `OVL_MAX_TICKS`-th `ms_tick` trips when no clean cycle report has arrived since the current run of current-limited reports began. A clean report restarts this span from zero.
- R5: After a trip, `pwm_en` stays 0 until `RST_TICKS` ticks have been counted. From the clock after that tick, `pwm_en` = 1 and `ss_req` = 1.
- R6: Soft-start lasts `SS_TICKS` ticks. After the last of them `ss_req` = 0 while `pwm_en` stays 1. Normal running never re-enters soft-start without a trip.
- R7: During the restart interval, cycle reports and their flags are ignored. They neither shorten the wait nor carry count into the next run.
- R8: `HOT_RUN` consecutive cycle reports with `cyc_hot` = 1 trip through the same restart path. A report with `cyc_hot` = 0 restarts the run.
- R9: Every trip clears the overload count, the span and the temperature run, so after a restart a full `OVL_EOC` overloaded cycles are again needed.
- R10: `cyc_ilim` and `cyc_hot` have no effect unless `cyc_done` = 1 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_done | input | 1 | One-clock pulse at the end of each switching cycle |
| cyc_ilim | input | 1 | Cycle was ended by the current limit (valid with `cyc_done`) |
| cyc_hot | input | 1 | Over-temperature seen in this cycle (valid with `cyc_done`) |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| pwm_en | output | 1 | Switching allowed |
| ss_req | output | 1 | Soft-start ramp requested |

## Verification
The overload counter is driven with several patterns. Unbroken runs of current-limited cycles show the exact trip cycle. Limited runs interleaved with clean cycles separate an up/down counter from one that resets, and from one that fails to saturate at zero. A single limited cycle followed by ticks only isolates the span timer. Repeating that with a clean cycle in the middle shows that the span restarts. Hot and cold cycle mixes check the consecutive-run rule. Flags held without `cyc_done`, and cycle reports sent during the restart wait, show that both are ignored. Retrying after a restart exposes any count carried across a trip.

// File: rtl/olp_pkg.sv
// Package: shared types of the overload fault sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package olp_pkg;

    // Operating phase of the sequencer.
    typedef enum logic [1:0] {
        PH_SOFT = 2'd0,  // switching with soft-start ramp
        PH_RUN  = 2'd1,  // normal switching
        PH_WAIT = 2'd2   // switching off, auto-restart wait
    } phase_t;

endpackage

// File: rtl/olp_ovl_counter.sv
// Module: up/down overload counter with a continuous-overload span timer.
// Counts current-limited cycles up and clean cycles down (saturating at 0),
// and optionally measures in ms ticks how long an unbroken run of limited
// cycles has lasted. Either reaching its limit raises a one-clock trip.
// Assumes: cyc_done is a one-clock pulse; clr has priority over counting.
module olp_ovl_counter #(
    parameter int OVL_EOC       = 3000,
    parameter int OVL_MAX_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic cyc_done,
    input  logic cyc_ilim,
    input  logic ms_tick,
    output logic trip
);
    localparam int CW = $clog2(OVL_EOC + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          ilim_cyc;
    logic          clean_cyc;
    logic          trip_cnt;
    logic          trip_span;

    assign ilim_cyc  = en && cyc_done && cyc_ilim;
    assign clean_cyc = en && cyc_done && !cyc_ilim;
    assign trip_cnt  = ilim_cyc && (cnt_q == CW'(OVL_EOC - 1));
    assign trip      = trip_cnt || trip_span;

    // Net overload count and the "inside a limited run" flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (ilim_cyc) begin
            cnt_q <= cnt_q + CW'(1);
            run_q <= 1'b1;
        end else if (clean_cyc) begin
            cnt_q <= (cnt_q == '0) ? '0 : cnt_q - CW'(1);
            run_q <= 1'b0;
        end
    end

    generate
        if (OVL_MAX_TICKS > 0) begin : g_span
            localparam int SW = $clog2(OVL_MAX_TICKS + 1);
            logic [SW-1:0] span_q;
            logic          span_inc;

            assign span_inc  = en && ms_tick && run_q && !clean_cyc;
            assign trip_span = span_inc && (span_q == SW'(OVL_MAX_TICKS - 1));

            // Milliseconds elapsed inside the current limited run.
            always_ff @(posedge clk) begin
                if (!rst_n || clr || clean_cyc) begin
                    span_q <= '0;
                end else if (span_inc) begin
                    span_q <= span_q + SW'(1);
                end
            end
        end else begin : g_nospan
            assign trip_span = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/olp_hot_filter.sv
// Module: consecutive-cycle filter for the over-temperature flag.
// Trips when HOT_RUN reported cycles in a row carry the flag; any cycle
// without it restarts the run.
// Assumes: cyc_done is a one-clock pulse; clr has priority.
module olp_hot_filter #(
    parameter int HOT_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic cyc_done,
    input  logic cyc_hot,
    output logic trip
);
    localparam int RW = $clog2(HOT_RUN + 1);

    logic [RW-1:0] run_q;

    assign trip = en && cyc_done && cyc_hot && (run_q == RW'(HOT_RUN - 1));

    // Length of the current run of hot cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (en && cyc_done) begin
            run_q <= cyc_hot ? run_q + RW'(1) : '0;
        end
    end

endmodule

// File: rtl/olp_phase_seq.sv
// Module: phase sequencer (soft-start, run, restart wait) with tick timer.
// A trip in soft-start or run enters the wait; the wait always runs its
// full length and then re-enters soft-start.
// Assumes: ms_tick is a one-clock pulse; trip is only meaningful off-wait.
module olp_phase_seq
    import olp_pkg::*;
#(
    parameter int SS_TICKS  = 8,
    parameter int RST_TICKS = 1000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   trip,
    input  logic   ms_tick,
    output phase_t phase
);
    localparam int TMAX = (SS_TICKS > RST_TICKS) ? SS_TICKS : RST_TICKS;
    localparam int TW   = $clog2(TMAX + 1);

    phase_t        ph_q;
    logic [TW-1:0] t_q;

    assign phase = ph_q;

    // Phase transitions and the shared tick timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_SOFT;
            t_q  <= '0;
        end else begin
            unique case (ph_q)
                PH_SOFT: begin
                    if (trip) begin
                        ph_q <= PH_WAIT;
                        t_q  <= '0;
                    end else if (ms_tick) begin
                        if (t_q == TW'(SS_TICKS - 1)) begin
                            ph_q <= PH_RUN;
                            t_q  <= '0;
                        end else begin
                            t_q <= t_q + TW'(1);
                        end
                    end
                end
                PH_RUN: begin
                    if (trip) begin
                        ph_q <= PH_WAIT;
                        t_q  <= '0;
                    end
                end
                PH_WAIT: begin
                    if (ms_tick) begin
                        if (t_q == TW'(RST_TICKS - 1)) begin
                            ph_q <= PH_SOFT;
                            t_q  <= '0;
                        end else begin
                            t_q <= t_q + TW'(1);
                        end
                    end
                end
                default: begin
                    ph_q <= PH_WAIT;
                    t_q  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/olp_fault_seq.sv
// Module: top of the overload fault sequencer.
// Combines the overload counter, the temperature filter and the phase
// sequencer; any trip clears all fault history and starts the restart wait.
// Assumes: cycle flags are valid only with cyc_done; all inputs synchronous.
module olp_fault_seq
    import olp_pkg::*;
#(
    parameter int OVL_EOC       = 3000,
    parameter int OVL_MAX_TICKS = 100,
    parameter int RST_TICKS     = 1000,
    parameter int SS_TICKS      = 8,
    parameter int HOT_RUN       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_done,
    input  logic cyc_ilim,
    input  logic cyc_hot,
    input  logic ms_tick,
    output logic pwm_en,
    output logic ss_req
);
    phase_t phase;
    logic   active;
    logic   trip_ovl;
    logic   trip_hot;
    logic   trip_any;

    assign active   = (phase != PH_WAIT);
    assign trip_any = trip_ovl || trip_hot;
    assign pwm_en   = active;
    assign ss_req   = (phase == PH_SOFT);

    olp_ovl_counter #(
        .OVL_EOC       (OVL_EOC),
        .OVL_MAX_TICKS (OVL_MAX_TICKS)
    ) u_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active),
        .clr      (trip_any),
        .cyc_done (cyc_done),
        .cyc_ilim (cyc_ilim),
        .ms_tick  (ms_tick),
        .trip     (trip_ovl)
    );

    olp_hot_filter #(
        .HOT_RUN (HOT_RUN)
    ) u_hot (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active),
        .clr      (trip_any),
        .cyc_done (cyc_done),
        .cyc_hot  (cyc_hot),
        .trip     (trip_hot)
    );

    olp_phase_seq #(
        .SS_TICKS  (SS_TICKS),
        .RST_TICKS (RST_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (trip_any),
        .ms_tick (ms_tick),
        .phase   (phase)
    );

endmodule

// File: rtl/olp_fault_seq_chk.sv
// Module: port-level property checker for olp_fault_seq, bound below.
// Assumes: synchronous active-low reset.
module olp_fault_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_done,
    input logic ms_tick,
    input logic pwm_en,
    input logic ss_req
);
    // R6: a soft-start request only while switching is allowed.
    assert_ss_needs_pwm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_req |-> pwm_en);

    // R6: normal running never returns to soft-start directly.
    assert_run_no_ss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !ss_req) |=> !ss_req);

    // R5: switching always resumes through soft-start.
    assert_resume_soft_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_en) |-> ss_req);

    // R7: the wait ends only on a tick, never on a cycle report.
    assert_wait_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && !ms_tick) |=> !pwm_en);

    // R10: no trip without a cycle report or a tick.
    assert_trip_needs_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !cyc_done && !ms_tick) |=> pwm_en);

endmodule

bind olp_fault_seq olp_fault_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_done (cyc_done),
    .ms_tick  (ms_tick),
    .pwm_en   (pwm_en),
    .ss_req   (ss_req)
);

// File: tb/sim_olp_fault_seq.sv
// Bench: behavioural reference model compared every clock, plus directed
// checks at the requirement boundaries.
module sim_olp_fault_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EOC  = 6;
    localparam int MAXT = 5;
    localparam int RSTT = 4;
    localparam int SST  = 3;
    localparam int HRUN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_done = 1'b0, cyc_ilim = 1'b0, cyc_hot = 1'b0, ms_tick = 1'b0;
    logic pwm_en, ss_req;

    int checks = 0;
    int failures = 0;
    int clocks = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    olp_fault_seq #(
        .OVL_EOC(EOC), .OVL_MAX_TICKS(MAXT), .RST_TICKS(RSTT),
        .SS_TICKS(SST), .HOT_RUN(HRUN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .cyc_ilim(cyc_ilim),
        .cyc_hot(cyc_hot), .ms_tick(ms_tick), .pwm_en(pwm_en), .ss_req(ss_req)
    );

    // Reference model state: 0 soft-start, 1 run, 2 waiting.
    int  m_ph = 0, m_ovl = 0, m_span = 0, m_hot = 0, m_t = 0;
    bit  m_inrun = 0;
    logic m_pwm = 1'b1, m_ss = 1'b1;
    string cur_req = "R1";

    always @(posedge clk) begin
        bit trip;
        bit was_run;
        trip = 0;
        if (!rst_n) begin
            m_ph = 0; m_ovl = 0; m_span = 0; m_hot = 0; m_t = 0; m_inrun = 0;
        end else if (m_ph != 2) begin
            was_run = m_inrun;
            if (cyc_done) begin
                if (cyc_ilim) begin
                    if (m_ovl + 1 >= EOC) trip = 1; else m_ovl++;
                    m_inrun = 1;
                end else begin
                    if (m_ovl > 0) m_ovl--;
                    m_inrun = 0;
                    m_span = 0;
                end
                if (cyc_hot) begin
                    if (m_hot + 1 >= HRUN) trip = 1; else m_hot++;
                end else m_hot = 0;
            end
            if (ms_tick && was_run && !(cyc_done && !cyc_ilim)) begin
                m_span++;
                if (m_span >= MAXT) trip = 1;
            end
            if (trip) begin
                m_ph = 2; m_ovl = 0; m_span = 0; m_hot = 0; m_t = 0; m_inrun = 0;
            end else if (m_ph == 0 && ms_tick) begin
                if (m_t + 1 >= SST) begin m_ph = 1; m_t = 0; end else m_t++;
            end
        end else if (ms_tick) begin
            if (m_t + 1 >= RSTT) begin m_ph = 0; m_t = 0; end else m_t++;
        end
        m_pwm = (m_ph != 2);
        m_ss  = (m_ph == 0);
        started = 1'b1;
    end

    task automatic chk(input string req, input logic act, input logic exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(cur_req, pwm_en, m_pwm, "model pwm_en");
            chk(cur_req, ss_req, m_ss, "model ss_req");
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        clocks++;
        if (clocks > 20000 && !finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", clocks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input logic d, input logic il, input logic ht,
                        input logic tk);
        cyc_done = d; cyc_ilim = il; cyc_hot = ht; ms_tick = tk;
        @(posedge clk);
        @(negedge clk);
        cyc_done = 0; cyc_ilim = 0; cyc_hot = 0; ms_tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) step(0, 0, 0, 0);
        chk("R1", pwm_en, 1'b1, "pwm_en in reset");
        chk("R1", ss_req, 1'b1, "ss_req in reset");
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        chk("R1", ss_req, 1'b1, "ss_req after reset");

        cur_req = "R6";
        ticks(SST - 1);
        chk("R6", ss_req, 1'b1, "ss_req before last tick");
        ticks(1);
        chk("R6", ss_req, 1'b0, "ss_req after soft-start");
        chk("R6", pwm_en, 1'b1, "pwm_en after soft-start");

        cur_req = "R10";
        for (int i = 0; i < 10; i++) step(0, 1, 1, 0);
        chk("R10", pwm_en, 1'b1, "flags without cyc_done");

        cur_req = "R3";
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0);
        chk("R3", pwm_en, 1'b1, "five limited cycles");
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        chk("R3", pwm_en, 1'b1, "count back to five");
        cur_req = "R2";
        step(1, 1, 0, 0);
        chk("R2", pwm_en, 1'b0, "trip at end-of-count");
        chk("R2", ss_req, 1'b0, "no soft-start while off");

        cur_req = "R7";
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0);
        ticks(RSTT - 1);
        chk("R7", pwm_en, 1'b0, "still waiting");
        cur_req = "R5";
        ticks(1);
        chk("R5", pwm_en, 1'b1, "resume after wait");
        chk("R5", ss_req, 1'b1, "resume in soft-start");
        ticks(SST);

        cur_req = "R9";
        for (int i = 0; i < EOC - 1; i++) step(1, 1, 0, 0);
        chk("R9", pwm_en, 1'b1, "count cleared by trip");
        step(1, 1, 0, 0);
        chk("R9", pwm_en, 1'b0, "retry trips again");
        ticks(RSTT + SST);

        cur_req = "R4";
        step(1, 1, 0, 0);
        ticks(MAXT - 1);
        chk("R4", pwm_en, 1'b1, "span below limit");
        ticks(1);
        chk("R4", pwm_en, 1'b0, "span trip");
        ticks(RSTT + SST);
        step(1, 1, 0, 0);
        ticks(MAXT - 2);
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        ticks(MAXT - 1);
        chk("R4", pwm_en, 1'b1, "span restarted by clean cycle");
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);

        cur_req = "R8";
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        step(1, 0, 0, 0);
        step(1, 0, 1, 0);
        step(1, 0, 1, 0);
        chk("R8", pwm_en, 1'b1, "broken hot run");
        step(1, 0, 1, 0);
        chk("R8", pwm_en, 1'b0, "hot run trip");
        ticks(RSTT + SST);

        cur_req = "R3";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        for (int i = 0; i < EOC - 1; i++) step(1, 1, 0, 0);
        chk("R3", pwm_en, 1'b1, "saturated at zero");
        step(1, 1, 0, 0);
        chk("R3", pwm_en, 1'b0, "trip after saturation");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule